// File: doc/BRIEF.md
# Resumable Stack-Parameter Block Copy Engine

This engine sits next to a processor's control unit and carries out a memory-to-memory block move. When the control unit pulses `start` for a block-move opcode, the engine reads a six-byte parameter block from the stack, one byte per cycle, at `sp + ofs`. The block holds a 16-bit byte count, a 16-bit source address and a 16-bit destination address. The engine then copies bytes in a two-cycle loop and raises `done_req` for one cycle, which ends the host instruction.

A persistent `busy` flop records that the parameters are already held inside the engine. Any interrupt stops the engine at once. When the control unit restarts the same opcode after the service routine, the engine goes straight back to the copy loop if `busy` is set. If `busy` is clear, it fetches the parameters again. An abort discards the held state.

An interrupt can also land in the completion cycle itself. A pending-done flag then makes the restarted instruction finish immediately, without copying the block a second time.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset `busy` is 0, and `mem_rd`, `mem_wr` and `done_req` are all 0.
- R2: In the six cycles that follow a fresh `start`, the engine issues reads at `sp + ofs + i` for i = 0 to 5, with modulo-2^16 arithmetic. The bytes are taken as count low, count high, source low, source high, destination low and destination high.
- R3: `busy` becomes 1 on the clock edge that ends the sixth parameter read. It therefore reads 1 in the first copy cycle and 0 during every parameter read.
- R4: Each byte takes two cycles. The first cycle reads from `src + k`. The next cycle writes the value just read to `dst + k`. A count value N moves N+1 bytes, with k running from N down to 0, and addresses wrap modulo 2^16.
- R5: After the write with k = 0, `busy` is 0. In the next cycle `done_req` is high for exactly one cycle and the engine then goes idle.
- R6: In any cycle where `irq` is high, no strobe and no `done_req` is issued. The engine goes idle and keeps `busy` and its held parameters.
- R7: A `start` while `busy` is 1 resumes directly with the read of the byte whose write had not completed, with no parameter reads.
- R8: An interrupt during the parameter fetch leaves `busy` at 0, so the next `start` fetches all six parameters again.
- R9: `abort` forces `busy` to 0, cancels any pending completion and suppresses strobes in that cycle. The next `start` does a full fetch.
- R10: If `irq` is high in the completion cycle, `done_req` is suppressed. The next `start` then gives `done_req` in the following cycle with no bus access. Later starts behave as fresh starts.
- R11: `start` is ignored while the engine is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Block-move opcode has begun (one-cycle pulse) |
| irq | input | 1 | Real interrupt; stops the engine |
| abort | input | 1 | Abort; stops the engine and clears held state |
| sp | input | 16 | Stack pointer (read only) |
| ofs | input | 8 | Offset of the parameter block above the stack pointer |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe; data is returned in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Copy loop entered and not finished |
| done_req | output | 1 | Completion request to the control unit |

## Verification
The bench first runs an uninterrupted copy with a stray `start` pulse in the middle of it. This separates a correct parameter order and descending copy order from a design that reacts to repeated starts. A second copy places its parameter block and its source across the top of the address space, which exposes any missing modulo wrap. Interrupts are then placed in the parameter fetch, in the middle of the copy loop and in the completion cycle, and an abort is placed on a write. Each case shows whether the restart refetches the parameters, resumes at the correct byte, or finishes at once, as each case requires.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [2:0] {
    BC_IDLE,
    BC_PARAM,
    BC_READ,
    BC_WRITE,
    BC_FINISH
  } bc_state_e;
endpackage

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
#(
  parameter int NPAR = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          irq,
  input  logic          abort,
  input  logic          cnt_zero,
  output bc_state_e     state,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          done_stb,
  output logic          par_ld,
  output logic          tmp_ld,
  output logic          cnt_dec
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NPAR - 1);

  logic halt;
  logic pend;

  assign halt = irq | abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BC_IDLE;
      idx   <= '0;
      busy  <= 1'b0;
      pend  <= 1'b0;
    end else if (abort) begin
      state <= BC_IDLE;
      busy  <= 1'b0;
      pend  <= 1'b0;
    end else if (irq) begin
      state <= BC_IDLE;
    end else begin
      case (state)
        BC_IDLE: begin
          if (start) begin
            idx <= '0;
            if (pend)      state <= BC_FINISH;
            else if (busy) state <= BC_READ;
            else           state <= BC_PARAM;
          end
        end
        BC_PARAM: begin
          if (idx == LAST_IDX) begin
            busy  <= 1'b1;
            state <= BC_READ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        BC_READ: state <= BC_WRITE;
        BC_WRITE: begin
          if (cnt_zero) begin
            busy  <= 1'b0;
            pend  <= 1'b1;
            state <= BC_FINISH;
          end else begin
            state <= BC_READ;
          end
        end
        BC_FINISH: begin
          pend  <= 1'b0;
          state <= BC_IDLE;
        end
        default: state <= BC_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_stb   = !halt && (state == BC_PARAM || state == BC_READ);
    wr_stb   = !halt && (state == BC_WRITE);
    done_stb = !halt && (state == BC_FINISH);
    par_ld   = !halt && (state == BC_PARAM);
    tmp_ld   = !halt && (state == BC_READ);
    cnt_dec  = !halt && (state == BC_WRITE) && !cnt_zero;
  end
endmodule

// File: rtl/blkcopy_dpath.sv
module blkcopy_dpath
  import blkcopy_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int OW   = 8,
  parameter int NPAR = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  bc_state_e     state,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] sp,
  input  logic [OW-1:0] ofs,
  input  logic [DW-1:0] mem_rdata,
  input  logic          par_ld,
  input  logic          tmp_ld,
  input  logic          cnt_dec,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cnt_zero
);
  localparam int CB = CW / DW;
  localparam int AB = AW / DW;

  logic [DW-1:0] pb [NPAR];
  logic [DW-1:0] tmp;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;
  logic [AW-1:0] src;
  logic [AW-1:0] dst;
  logic [AW-1:0] cnt_a;
  logic [AW-1:0] base;

  for (genvar i = 0; i < CB; i++) begin : g_cnt
    assign cnt[i*DW +: DW] = pb[i];
  end
  for (genvar i = 0; i < AB; i++) begin : g_adr
    assign src[i*DW +: DW] = pb[CB + i];
    assign dst[i*DW +: DW] = pb[CB + AB + i];
  end

  assign cnt_next = cnt - 1'b1;
  assign cnt_zero = (cnt == '0);
  assign cnt_a    = AW'(cnt);
  assign base     = sp + AW'(ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NPAR; b++) pb[b] <= '0;
      tmp <= '0;
    end else begin
      for (int b = 0; b < NPAR; b++) begin
        if (par_ld && idx == IW'(b)) pb[b] <= mem_rdata;
        else if (cnt_dec && b < CB) pb[b] <= cnt_next[(b % CB)*DW +: DW];
      end
      if (tmp_ld) tmp <= mem_rdata;
    end
  end

  always_comb begin
    case (state)
      BC_PARAM: mem_addr = base + AW'(idx);
      BC_READ:  mem_addr = src + cnt_a;
      BC_WRITE: mem_addr = dst + cnt_a;
      default:  mem_addr = '0;
    endcase
  end

  assign mem_wdata = tmp;
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          irq,
  input  logic          abort,
  input  logic [AW-1:0] sp,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done_req
);
  localparam int NPAR = CW / DW + 2 * (AW / DW);
  localparam int IW   = $clog2(NPAR);

  bc_state_e     state;
  logic [IW-1:0] idx;
  logic          cnt_zero;
  logic          par_ld;
  logic          tmp_ld;
  logic          cnt_dec;

  blkcopy_ctrl #(.NPAR(NPAR), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .irq      (irq),
    .abort    (abort),
    .cnt_zero (cnt_zero),
    .state    (state),
    .idx      (idx),
    .busy     (busy),
    .rd_stb   (mem_rd),
    .wr_stb   (mem_wr),
    .done_stb (done_req),
    .par_ld   (par_ld),
    .tmp_ld   (tmp_ld),
    .cnt_dec  (cnt_dec)
  );

  blkcopy_dpath #(
    .AW(AW), .DW(DW), .CW(CW), .OW(OW), .NPAR(NPAR), .IW(IW)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .idx       (idx),
    .sp        (sp),
    .ofs       (ofs),
    .mem_rdata (mem_rdata),
    .par_ld    (par_ld),
    .tmp_ld    (tmp_ld),
    .cnt_dec   (cnt_dec),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cnt_zero  (cnt_zero)
  );
endmodule

// File: rtl/blkcopy_engine_chk.sv
module blkcopy_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          abort,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          done_req
);
  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R4
  wr_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_rd == 1'b0) && (mem_wdata == $past(mem_rdata)) && $past(mem_rd));

  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mem_rd));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_req |-> !busy);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_req |=> !done_req);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !mem_rd && !mem_wr && !done_req);

  // R9
  abort_clr_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
endmodule

bind blkcopy_engine blkcopy_engine_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_blkcopy_engine.sv
module tb_blkcopy_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        irq = 1'b0;
  logic        abort = 1'b0;
  logic [15:0] sp = '0;
  logic [7:0]  ofs = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy;
  logic        done_req;

  int nvec = 0;
  int nfail = 0;

  typedef struct {
    int          kind;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        bsy;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] mem [logic [15:0]];

  always #10 clk = ~clk;

  blkcopy_engine dut (
    .clk(clk), .rst(rst), .start(start), .irq(irq), .abort(abort),
    .sp(sp), .ofs(ofs), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done_req(done_req)
  );

  function automatic logic [7:0] mget(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always begin
    @(posedge clk);
    if (mem_wr) mem[mem_addr] = mem_wdata;
    #5;
    mem_rdata = mget(mem_addr);
  end

  task automatic check(string tag, int act, int exp_v);
    nvec++;
    if (act != exp_v) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (mem_rd || mem_wr || done_req)) begin
      nvec++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected: actual rd=%0b wr=%0b done=%0b addr=%0h expected no activity",
                 mem_rd, mem_wr, done_req, mem_addr);
      end else begin
        exp_t e;
        int   k;
        e = q.pop_front();
        k = done_req ? 2 : (mem_wr ? 1 : 0);
        if (k != e.kind || (k != 2 && mem_addr != e.addr) ||
            (k == 1 && mem_wdata != e.data) || busy != e.bsy) begin
          nfail++;
          $display("FAIL %s: actual kind=%0d addr=%0h data=%0h busy=%0b expected kind=%0d addr=%0h data=%0h busy=%0b",
                   e.tag, k, mem_addr, mem_wdata, busy, e.kind, e.addr, e.data, e.bsy);
        end
      end
    end
  end

  task automatic push(int kind, logic [15:0] a, logic [7:0] d, logic b, string tag);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.bsy = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic go();
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic put_params(logic [15:0] base, logic [15:0] cnt, logic [15:0] s, logic [15:0] d);
    mem[base]         = cnt[7:0];
    mem[base + 16'd1] = cnt[15:8];
    mem[base + 16'd2] = s[7:0];
    mem[base + 16'd3] = s[15:8];
    mem[base + 16'd4] = d[7:0];
    mem[base + 16'd5] = d[15:8];
  endtask

  task automatic plan_params(logic [15:0] base, int n);
    for (int i = 0; i < n; i++)
      push(0, base + 16'(i), 8'h00, 1'b0, (i == 5) ? "R3" : "R2");
  endtask

  task automatic plan_copy(logic [15:0] s, logic [15:0] d, int from, string tag);
    for (int k = from; k >= 0; k--) begin
      push(0, s + 16'(k), 8'h00, 1'b1, tag);
      push(1, d + 16'(k), mget(s + 16'(k)), 1'b1, tag);
    end
    push(2, 16'h0, 8'h00, 1'b0, "R5");
  endtask

  task automatic fill(logic [15:0] s, int n, int seed);
    for (int k = 0; k < n; k++) mem[s + 16'(k)] = 8'((k * 37 + seed) & 8'hff);
  endtask

  task automatic drain(string tag);
    int guard = 0;
    while (q.size() != 0 && guard < 200) begin
      step(1);
      guard++;
    end
    step(3);
    check(tag, q.size(), 0);
  endtask

  task automatic check_copy(logic [15:0] s, logic [15:0] d, int n);
    for (int k = 0; k < n; k++)
      check("R4 memory", int'(mget(d + 16'(k))), int'(mget(s + 16'(k))));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    step(4);
    // R1: state during and after reset
    check("R1 busy", int'(busy), 0);
    check("R1 strobes", int'({mem_rd, mem_wr, done_req}), 0);
    rst = 1'b0;
    step(2);
    check("R1 busy after", int'(busy), 0);

    // Basic copy, count 3 (4 bytes), stray start in cycle 3 (R11)
    sp = 16'h01F0; ofs = 8'h02;
    put_params(16'h01F2, 16'd3, 16'h1000, 16'h2000);
    fill(16'h1000, 4, 5);
    plan_params(16'h01F2, 6);
    plan_copy(16'h1000, 16'h2000, 3, "R4");
    go();
    step(1);
    start = 1'b1;
    step(1);
    start = 1'b0;
    drain("R11 sequence");
    check_copy(16'h1000, 16'h2000, 4);
    check("R5 busy idle", int'(busy), 0);

    // Wrap-around of parameter block and source (R2, R4)
    sp = 16'hFFFC; ofs = 8'h03;
    put_params(16'hFFFF, 16'd1, 16'hFFFF, 16'h0010);
    plan_params(16'hFFFF, 6);
    plan_copy(16'hFFFF, 16'h0010, 1, "R4 wrap");
    go();
    drain("R2 wrap");
    check_copy(16'hFFFF, 16'h0010, 2);

    // Interrupt in the copy loop, then resume (R6, R7)
    sp = 16'h0300; ofs = 8'h10;
    put_params(16'h0310, 16'd4, 16'h1100, 16'h2100);
    fill(16'h1100, 5, 11);
    plan_params(16'h0310, 6);
    push(0, 16'h1104, 0, 1'b1, "R4"); push(1, 16'h2104, mget(16'h1104), 1'b1, "R4");
    push(0, 16'h1103, 0, 1'b1, "R4"); push(1, 16'h2103, mget(16'h1103), 1'b1, "R4");
    go();
    step(10);
    irq = 1'b1;
    step(1);
    irq = 1'b0;
    step(2);
    check("R6 busy held", int'(busy), 1);
    check("R6 queue", q.size(), 0);
    plan_copy(16'h1100, 16'h2100, 2, "R7 resume");
    go();
    drain("R7 sequence");
    check_copy(16'h1100, 16'h2100, 5);

    // Interrupt during parameter fetch (R8)
    sp = 16'h0400; ofs = 8'h00;
    put_params(16'h0400, 16'd0, 16'h1200, 16'h2200);
    fill(16'h1200, 1, 77);
    plan_params(16'h0400, 2);
    go();
    step(2);
    irq = 1'b1;
    step(1);
    irq = 1'b0;
    step(2);
    check("R8 busy clear", int'(busy), 0);
    plan_params(16'h0400, 6);
    plan_copy(16'h1200, 16'h2200, 0, "R8 refetch");
    go();
    drain("R8 sequence");

    // Abort on the first write (R9)
    sp = 16'h0500; ofs = 8'h04;
    put_params(16'h0504, 16'd2, 16'h1300, 16'h2300);
    fill(16'h1300, 3, 200);
    plan_params(16'h0504, 6);
    push(0, 16'h1302, 0, 1'b1, "R9");
    go();
    step(7);
    abort = 1'b1;
    step(1);
    abort = 1'b0;
    step(2);
    check("R9 busy cleared", int'(busy), 0);
    check("R9 queue", q.size(), 0);
    plan_params(16'h0504, 6);
    plan_copy(16'h1300, 16'h2300, 2, "R9 refetch");
    go();
    drain("R9 sequence");
    check_copy(16'h1300, 16'h2300, 3);

    // Interrupt in the completion cycle (R10)
    sp = 16'h0600; ofs = 8'h00;
    put_params(16'h0600, 16'd0, 16'h1400, 16'h2400);
    fill(16'h1400, 1, 9);
    plan_params(16'h0600, 6);
    push(0, 16'h1400, 0, 1'b1, "R10"); push(1, 16'h2400, mget(16'h1400), 1'b1, "R10");
    go();
    step(8);
    irq = 1'b1;
    step(1);
    irq = 1'b0;
    step(2);
    check("R10 no done", q.size(), 0);
    check("R10 busy", int'(busy), 0);
    push(2, 16'h0, 8'h00, 1'b0, "R10 immediate done");
    go();
    check("R10 done cycle", int'(done_req), 1);
    drain("R10 sequence");
    plan_params(16'h0600, 6);
    plan_copy(16'h1400, 16'h2400, 0, "R10 fresh");
    go();
    drain("R10 fresh sequence");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule